// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable logic device. It receives the OR of its product terms (`sop_in`) and presents it either straight through (combinational mode) or through a D flip-flop (registered mode). Either way, the output can be inverted for active-low use. The flip-flop runs on one of two clock inputs, chosen per cell. The cell also returns a feedback bit to the logic array. That bit is either the register's true value or the level on the pin, so the pin can act as an input while the register keeps running.

Four configuration bits set the cell up:

| Bit | Meaning |
|-----|---------|
| `cfg[0]` | 1 = registered, 0 = combinational |
| `cfg[1]` | 1 = inverted (active-low) output, 0 = true output |
| `cfg[2]` | 1 = `clk_b` drives the register, 0 = `clk_a` drives it |
| `cfg[3]` | 1 = feedback from `pin_in`, 0 = feedback from the register |

The register is a two-state machine with states `Q_CLR` (holds 0) and `Q_SET` (holds 1). On each rising edge of the selected clock, the cell picks one next-state action. The actions, from highest priority to lowest, are:

- `ACT_PRELOAD`: load `preload_val`, when `preload_en` is high.
- `ACT_PRESET`: go to `Q_SET`, when `preset` is high.
- `ACT_CAPTURE`: take `sop_in`, otherwise.

The asynchronous clear sends the machine to `Q_CLR` at once, with no clock edge. It fires when either `rst_n` (global reset) or `por_n` (power-up reset) is low, and it overrides every action. The output enable term passes through to `oe_out` unchanged.

Top module: `macro_out_cell`

## Requirements
- R1: With `cfg[0]`=0, `out_val` equals `sop_in` (inverted when `cfg[1]`=1) in the same cycle, with no clock edge.
- R2: With `cfg[0]`=1, `out_val` shows the register, which on each rising edge of the selected clock captures `sop_in` when neither preload nor preset is active.
- R3: `cfg[1]`=1 inverts `out_val` in both modes; `cfg[1]`=0 leaves it true.
- R4: `cfg[2]`=0 selects `clk_a` and `cfg[2]`=1 selects `clk_b`; an edge on the unselected clock leaves the register unchanged.
- R5: `rst_n` low clears the register to 0 immediately, without a clock edge.
- R6: `por_n` low clears the register to 0 immediately, exactly like `rst_n`.
- R7: `preset` high with `preload_en` low sets the register to 1 at the next selected clock edge, whatever `sop_in` is.
- R8: `preload_en` high loads `preload_val` at the next selected clock edge, overriding both `preset` and `sop_in`.
- R9: `fb_out` equals the register's true (non-inverted) value when `cfg[3]`=0, and equals `pin_in` when `cfg[3]`=1, regardless of polarity or mode.
- R10: While `rst_n` or `por_n` is low, selected clock edges with preload or preset active leave the register at 0.
- R11: `oe_out` equals `oe_term` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock source |
| clk_b | input | 1 | Second clock source |
| rst_n | input | 1 | Global asynchronous clear, active low |
| por_n | input | 1 | Power-up clear, active low |
| cfg | input | 4 | Cell configuration bits (see table above) |
| sop_in | input | 1 | Sum-of-products term from the array |
| oe_term | input | 1 | Output enable product term |
| preset | input | 1 | Synchronous set to 1 |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value forced by preload |
| pin_in | input | 1 | Level observed on the pad |
| out_val | output | 1 | Data toward the pad |
| oe_out | output | 1 | Output enable toward the pad |
| fb_out | output | 1 | Feedback to the logic array |

## Verification
The results fall due at different times:

- Combinational results (`out_val` in combinational mode, `fb_out` from the pin, and `oe_out`) are due in the same cycle. The bench samples them 1 ns after it drives the inputs on a falling edge.
- Register results are due one selected-clock edge later. The bench gates each clock on for exactly one pulse, then samples on the next falling edge.
- A reset clear is due at once. The bench checks it before any further clock pulse.

A pulse on the unselected clock is followed by a check that the register has not moved. The bench sweeps all 16 configurations against all 16 combinations of data, pin, preset and preload, and predicts each result arithmetically from the requirements.

// File: rtl/macro_out_cell_pkg.sv
package macro_out_cell_pkg;

    localparam int CFG_W   = 4;
    localparam int NUM_CLK = 2;

    typedef enum logic {
        Q_CLR = 1'b0,
        Q_SET = 1'b1
    } qstate_e;

    typedef enum logic [1:0] {
        ACT_CAPTURE = 2'd0,
        ACT_PRESET  = 2'd1,
        ACT_PRELOAD = 2'd2
    } act_e;

    typedef struct packed {
        logic fb_pin;
        logic clk_b;
        logic invert;
        logic registered;
    } cell_cfg_t;

endpackage

// File: rtl/mcell_clk_mux.sv
module mcell_clk_mux #(
    parameter int NUM_CLK = 2,
    localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clk_bus,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_o
);

    always_comb begin
        clk_o = clk_bus[0];
        for (int i = 1; i < NUM_CLK; i++) begin
            if (sel == SEL_W'(i)) clk_o = clk_bus[i];
        end
    end

endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
    import macro_out_cell_pkg::*;
(
    input  logic    clk,
    input  logic    clr_n,
    input  logic    d,
    input  logic    preset,
    input  logic    preload_en,
    input  logic    preload_val,
    output qstate_e q_state
);

    act_e    act;
    qstate_e q_next;

    // Action priority: preload, then preset, then capture.
    always_comb begin
        if (preload_en)  act = ACT_PRELOAD;
        else if (preset) act = ACT_PRESET;
        else             act = ACT_CAPTURE;
    end

    always_comb begin
        unique case (act)
            ACT_PRELOAD: q_next = preload_val ? Q_SET : Q_CLR;
            ACT_PRESET:  q_next = Q_SET;
            ACT_CAPTURE: q_next = d ? Q_SET : Q_CLR;
            default:     q_next = Q_CLR;
        endcase
    end

    // State register with asynchronous clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_state <= Q_CLR;
        else        q_state <= q_next;
    end

    AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!clr_n)
        preload_en |=> (q_state == ($past(preload_val) ? Q_SET : Q_CLR))); // R8

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!clr_n)
        (!preload_en && preset) |=> (q_state == Q_SET)); // R7

    AST_CAPTURE_D: assert property (@(posedge clk) disable iff (!clr_n)
        (!preload_en && !preset) |=> (q_state == ($past(d) ? Q_SET : Q_CLR))); // R2

endmodule

// File: rtl/mcell_out_mux.sv
module mcell_out_mux
    import macro_out_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  qstate_e   q_state,
    input  logic      sop_in,
    input  logic      pin_in,
    output logic      out_val,
    output logic      fb_out
);

    logic pre_pol;

    always_comb begin
        pre_pol = cfg.registered ? (q_state == Q_SET) : sop_in;
        out_val = pre_pol ^ cfg.invert;
        fb_out  = cfg.fb_pin ? pin_in : (q_state == Q_SET);
    end

endmodule

// File: rtl/macro_out_cell.sv
module macro_out_cell
    import macro_out_cell_pkg::*;
(
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             sop_in,
    input  logic             oe_term,
    input  logic             preset,
    input  logic             preload_en,
    input  logic             preload_val,
    input  logic             pin_in,
    output logic             out_val,
    output logic             oe_out,
    output logic             fb_out
);

    cell_cfg_t cfg_s;
    logic      clk_sel;
    logic      clr_n;
    qstate_e   q_state;

    assign cfg_s  = cell_cfg_t'(cfg);
    assign clr_n  = rst_n & por_n;
    assign oe_out = oe_term;

    mcell_clk_mux #(.NUM_CLK(NUM_CLK)) u_clk_mux (
        .clk_bus ({clk_b, clk_a}),
        .sel     (cfg_s.clk_b),
        .clk_o   (clk_sel)
    );

    mcell_reg u_reg (
        .clk         (clk_sel),
        .clr_n       (clr_n),
        .d           (sop_in),
        .preset      (preset),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .q_state     (q_state)
    );

    mcell_out_mux u_out_mux (
        .cfg     (cfg_s),
        .q_state (q_state),
        .sop_in  (sop_in),
        .pin_in  (pin_in),
        .out_val (out_val),
        .fb_out  (fb_out)
    );

    always_comb begin
        if (cfg_s.fb_pin) begin
            AST_FB_FROM_PIN: assert (fb_out == pin_in); // R9
        end
        if (!cfg_s.registered && !cfg_s.invert) begin
            AST_COMB_TRUE: assert (out_val == sop_in); // R1
        end
    end

endmodule

// File: tb/macro_out_cell_bench.sv
module macro_out_cell_bench;

    logic sys_clk = 1'b0;
    always #4 sys_clk = ~sys_clk;

    logic en_a = 1'b0, en_b = 1'b0;
    logic clk_a, clk_b;
    assign clk_a = sys_clk & en_a;
    assign clk_b = sys_clk & en_b;

    logic       rst_n = 1'b0, por_n = 1'b0;
    logic [3:0] cfg = 4'b0001;
    logic sop_in = 0, oe_term = 0, preset = 0, preload_en = 0, preload_val = 0, pin_in = 0;
    logic out_val, oe_out, fb_out;

    int n_cmp = 0, n_bad = 0;
    logic exp_q = 1'b0;

    macro_out_cell u_macro_out_cell (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .por_n(por_n), .cfg(cfg),
        .sop_in(sop_in), .oe_term(oe_term), .preset(preset),
        .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
        .out_val(out_val), .oe_out(oe_out), .fb_out(fb_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (cfg=%b)", tag, act, exp, cfg);
        end
    endtask

    // One pulse on clock 0 (clk_a) or 1 (clk_b); returns 1 ns after the following falling edge.
    task automatic pulse(input logic which);
        @(negedge sys_clk);
        if (which) en_b = 1'b1; else en_a = 1'b1;
        @(negedge sys_clk);
        en_a = 1'b0;
        en_b = 1'b0;
        #1;
    endtask

    function automatic logic exp_out();
        return (cfg[0] ? exp_q : sop_in) ^ cfg[1];
    endfunction

    function automatic logic exp_fb();
        return cfg[3] ? pin_in : exp_q;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge sys_clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        // Reset state, with edges arriving during reset (R5, R6, R10)
        preload_en = 1'b1; preload_val = 1'b1; preset = 1'b1;
        pulse(1'b0);
        chk("R5 reset state out", out_val, 1'b0);
        chk("R5 reset state fb", fb_out, 1'b0);
        @(negedge sys_clk);
        preload_en = 0; preset = 0; rst_n = 1; por_n = 1;

        // Sweep every configuration against every stimulus combination
        for (int c = 0; c < 16; c++) begin
            @(negedge sys_clk);
            cfg = 4'(c);
            for (int k = 0; k < 16; k++) begin
                @(negedge sys_clk);
                sop_in = k[0]; pin_in = k[1]; preset = k[2];
                preload_en = k[3]; preload_val = ~k[0]; oe_term = k[0] ^ k[1];
                #1;
                chk(cfg[0] ? "R2 out before edge" : "R1 comb out", out_val, exp_out());
                chk("R3 polarity/R9 fb", fb_out, exp_fb());
                chk("R11 oe", oe_out, oe_term);
                pulse(~cfg[2]);
                chk("R4 unselected clock out", out_val, exp_out());
                chk("R4 unselected clock fb", fb_out, exp_fb());
                pulse(cfg[2]);
                if (preload_en)  exp_q = preload_val;
                else if (preset) exp_q = 1'b1;
                else             exp_q = sop_in;
                chk(preload_en ? "R8 preload" : (preset ? "R7 preset" : "R2 capture"),
                    out_val, exp_out());
                chk("R9 fb after edge", fb_out, exp_fb());
            end
        end

        // Asynchronous clears in registered, true-output, clk_a, register-feedback mode
        @(negedge sys_clk);
        cfg = 4'b0001; preload_en = 0; preset = 1;
        pulse(1'b0);
        chk("R7 preset before clear", out_val, 1'b1);
        @(negedge sys_clk);
        rst_n = 1'b0;
        #1;
        chk("R5 async clear out", out_val, 1'b0);
        chk("R5 async clear fb", fb_out, 1'b0);
        preload_en = 1'b1; preload_val = 1'b1;
        pulse(1'b0);
        chk("R10 reset beats preload/preset", out_val, 1'b0);
        @(negedge sys_clk);
        rst_n = 1'b1; preload_en = 1'b0; preset = 1'b1;
        pulse(1'b0);
        chk("R7 preset after release", out_val, 1'b1);
        @(negedge sys_clk);
        por_n = 1'b0;
        #1;
        chk("R6 power-up clear out", out_val, 1'b0);
        pulse(1'b0);
        chk("R10 por beats preset", out_val, 1'b0);
        @(negedge sys_clk);
        por_n = 1'b1; preset = 1'b0; sop_in = 1'b1;
        pulse(1'b0);
        chk("R2 capture after por", out_val, 1'b1);

        summary();
    end

endmodule